// File: doc/BRIEF.md
# Two-Wire Slave Control Register Bank

This block is a slave on a two-wire serial bus (I2C, 7-bit addressing only) that gives a host controller write and read access to a small bank of byte-wide control registers. Fourteen registers, at indices 00h to 0Dh, can be written and read back. Their contents drive downstream switching and volume logic as one flat parallel bus. A fifteenth index, 0Eh, returns a status byte that comes from outside the block and cannot be written.

The block runs on a system clock that is much faster than the serial clock. Both bus lines pass through a two-flop synchroniser. Bus edges, start conditions and stop conditions are found by comparing successive synchronised samples. A single select pin chooses which of two slave addresses the block answers to.

A host stores a byte with this sequence: start, write address, register index, data, stop. To fetch a byte, the host first sends the write address and the register index. It then issues a repeated start with the read address and clocks in one byte, which it does not acknowledge. The block does not stretch the clock, does not accept 10-bit addresses and ignores general calls.

Top module: `ctl_regbank_i2c`

## Requirements
- R1: After reset, every byte of `ctl_bus` is 00h and `sda_pull` is 0, so the data line is released.
- R2: With `addr_sel` low, the address bytes 94h (write) and 95h (read) are acknowledged. An acknowledge is the data line held low during the ninth clock of the byte.
- R3: With `addr_sel` high, the address bytes 96h and 97h are acknowledged. Any other address byte, including the pair of the other pin setting, is not acknowledged. After such a byte, the data line stays released, including on later bytes, until the next start condition.
- R4: The sequence start, write address, index, data, stop acknowledges all three bytes. For an index below 0Eh, it stores the data in register n, which appears on `ctl_bus[8n+7:8n]`.
- R5: The sequence start, write address, index, repeated start, read address returns the selected register byte on the data line, most significant bit first, one bit per serial clock.
- R6: Reading index 0Eh returns the current value of `status_in`.
- R7: A write whose index is 0Eh or higher has all its bytes acknowledged, but it changes no byte of `ctl_bus`.
- R8: Reading an index above 0Eh returns 00h.
- R9: The block changes its drive of the data line only while the serial clock is low, so every bit it sends stays stable while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line (asynchronous) |
| sda_in | input | 1 | Serial data line as seen on the bus (asynchronous) |
| addr_sel | input | 1 | Chooses the slave address pair: 0 gives 94h/95h, 1 gives 96h/97h |
| status_in | input | 8 | External status byte, returned at index 0Eh |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |
| ctl_bus | output | 112 | Register n is on bits [8n+7:8n], for n from 0 to 13 |

## Verification
The hardest situation to reach from the ports is the read path. The pointer must be loaded in one address phase, and the bus must then return through a repeated start, with no stop, before the read address arrives. The bench models an open-drain bus: the line is low whenever either the master or the block pulls it. Its master tasks build exactly that two-phase sequence, sample each returned bit early and late in the serial-clock high phase, and hand the byte to a scoreboard, which compares it with values predicted from a model of the registers. Rejected addresses and out-of-range indices are mixed into the same stream. This shows that after a NACK the block keeps the line released on later bytes, and that writes it ignores leave the parallel bus untouched.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int          NUM_RW_DEF    = 14;
    localparam logic [6:0]  ADDR_BASE_DEF = 7'h4A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } link_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic [6:0] own_addr(input logic [6:0] base, input logic sel);
        return {base[6:1], sel};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import sreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_pipe[STAGES-1];
        ev.sda      = sda_pipe[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_q;
        ev.scl_fall = ~ev.scl & scl_q;
        ev.start    = ev.scl & scl_q & sda_q & ~ev.sda;
        ev.stop     = ev.scl & scl_q & ~sda_q & ev.sda;
    end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import sreg_pkg::*;
#(
    parameter int         NUM_RW    = NUM_RW_DEF,
    parameter logic [6:0] ADDR_BASE = ADDR_BASE_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev,
    input  logic       addr_sel,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output wr_req_t    wr,
    output logic       sda_pull
);

    link_state_t state;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic        in_ack;
    logic        rw;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            in_ack   <= 1'b0;
            rw       <= 1'b0;
            ptr      <= '0;
            wr       <= '0;
            sda_pull <= 1'b0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                state    <= ST_IDLE;
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (ev.scl_rise && !in_ack && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && in_ack) begin
                            in_ack   <= 1'b0;
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            case (state)
                                ST_ADDR: begin
                                    if (rw) begin
                                        state    <= ST_RDATA;
                                        shreg    <= rd_data;
                                        sda_pull <= ~rd_data[7];
                                    end else begin
                                        state <= ST_PTR;
                                    end
                                end
                                ST_PTR:  state <= ST_WDATA;
                                default: state <= ST_WAIT;
                            endcase
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == own_addr(ADDR_BASE, addr_sel)) begin
                                    in_ack   <= 1'b1;
                                    sda_pull <= 1'b1;
                                    rw       <= shreg[0];
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else begin
                                in_ack   <= 1'b1;
                                sda_pull <= 1'b1;
                                if (state == ST_PTR) begin
                                    ptr <= shreg;
                                end else if (ptr < 8'(NUM_RW)) begin
                                    wr.en   <= 1'b1;
                                    wr.idx  <= ptr;
                                    wr.data <= shreg;
                                end
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_pull <= 1'b0;
                                state    <= ST_RACK;
                            end else begin
                                shreg    <= {shreg[6:0], 1'b0};
                                sda_pull <= ~shreg[6];
                                bitcnt   <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) state <= ST_WAIT;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: the drive may move only while the serial clock is low, or when a start or stop releases it
    assert_sda_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        (sda_pull != $past(sda_pull)) |-> (!ev.scl || $past(ev.start) || $past(ev.stop)));

    // R3: once idle or waiting after a rejected address, the line stays released
    assert_release_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT || state == ST_IDLE) |-> !sda_pull);

endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
    import sreg_pkg::*;
#(
    parameter int NUM_RW = NUM_RW_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_req_t             wr,
    input  logic [7:0]          status_in,
    input  logic [7:0]          rd_idx,
    output logic [7:0]          rd_data,
    output logic [NUM_RW*8-1:0] ctl_bus
);

    localparam int IW = $clog2(NUM_RW);

    logic [7:0] regs [NUM_RW];

    for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr.en && wr.idx == 8'(i))
                regs[i] <= wr.data;
        end
        assign ctl_bus[8*i +: 8] = regs[i];
    end

    always_comb begin
        if (rd_idx < 8'(NUM_RW))
            rd_data = regs[rd_idx[IW-1:0]];
        else if (rd_idx == 8'(NUM_RW))
            rd_data = status_in;
        else
            rd_data = 8'h00;
    end

    // R7: no write request ever targets the status index or beyond
    assert_write_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (wr.idx < 8'(NUM_RW)));

    // R7: without a write request the parallel bus holds its value
    assert_bus_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> (ctl_bus == $past(ctl_bus)));

endmodule

// File: rtl/ctl_regbank_i2c.sv
module ctl_regbank_i2c
    import sreg_pkg::*;
#(
    parameter int         NUM_RW      = NUM_RW_DEF,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_BASE   = ADDR_BASE_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic                addr_sel,
    input  logic [7:0]          status_in,
    output logic                sda_pull,
    output logic [NUM_RW*8-1:0] ctl_bus
);

    line_ev_t   ev;
    wr_req_t    wr;
    logic [7:0] ptr;
    logic [7:0] rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_byte_engine #(.NUM_RW(NUM_RW), .ADDR_BASE(ADDR_BASE)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .wr       (wr),
        .sda_pull (sda_pull)
    );

    ctl_reg_file #(.NUM_RW(NUM_RW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .status_in (status_in),
        .rd_idx    (ptr),
        .rd_data   (rd_data),
        .ctl_bus   (ctl_bus)
    );

endmodule

// File: tb/ctl_regbank_i2c_test.sv
module ctl_regbank_i2c_test;

    localparam int NRW = 14;
    localparam int Q   = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           scl = 1'b1;
    logic           m_low = 1'b0;
    logic           addr_sel = 1'b0;
    logic [7:0]     status_in = 8'h00;
    logic           sda_pull;
    logic [NRW*8-1:0] ctl_bus;
    logic           sda_line;

    assign sda_line = !(m_low || sda_pull);

    always #10 clk = ~clk;

    ctl_regbank_i2c uut (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl),
        .sda_in    (sda_line),
        .addr_sel  (addr_sel),
        .status_in (status_in),
        .sda_pull  (sda_pull),
        .ctl_bus   (ctl_bus)
    );

    int total = 0;
    int bad   = 0;
    logic [7:0] model [NRW];
    logic [7:0] exp_val [$];
    string      exp_tag [$];
    logic [7:0] got_val [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            while (got_val.size() > 0 && exp_val.size() > 0) begin
                logic [7:0] g;
                logic [7:0] e;
                string      t;
                g = got_val.pop_front();
                e = exp_val.pop_front();
                t = exp_tag.pop_front();
                check(g == e, t, g, e);
            end
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; scl = 1'b1; wq();
        m_low = 1'b1; wq();
        scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; wq();
        scl = 1'b1; wq();
        m_low = 1'b1; wq();
        scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq();
        scl = 1'b1; wq();
        m_low = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; wq();
            scl = 1'b1; wq(); wq();
            scl = 1'b0;
        end
        m_low = 1'b0; wq();
        scl = 1'b1; wq();
        ack = !sda_line; wq();
        scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, output bit stable);
        stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            logic s1;
            m_low = 1'b0; wq();
            scl = 1'b1; wq();
            s1 = sda_line; wq();
            if (s1 != sda_line) stable = 1'b0;
            b[i] = sda_line;
            scl = 1'b0;
        end
        m_low = 1'b0; wq();
        scl = 1'b1; wq(); wq();
        scl = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] dev, input logic [7:0] idx, input logic [7:0] d,
                             input string req, input bit want_ack);
        bit a0, a1, a2;
        bus_start();
        send_byte(dev, a0);
        send_byte(idx, a1);
        send_byte(d, a2);
        bus_stop();
        check(a0 == want_ack, {req, " addr ack"}, a0, want_ack);
        check(a1 == want_ack, {req, " index ack"}, a1, want_ack);
        check(a2 == want_ack, {req, " data ack"}, a2, want_ack);
        if (want_ack && idx < NRW) model[idx] = d;
    endtask

    task automatic reg_read(input logic [7:0] dev, input logic [7:0] idx, input logic [7:0] e,
                            input string req);
        bit a0, a1, a2, st;
        logic [7:0] b;
        exp_val.push_back(e);
        exp_tag.push_back(req);
        bus_start();
        send_byte(dev, a0);
        send_byte(idx, a1);
        bus_rstart();
        send_byte(dev | 8'h01, a2);
        recv_byte(b, st);
        bus_stop();
        got_val.push_back(b);
        check(a0 && a1 && a2, {req, " acks"}, {a0, a1, a2}, 3'b111);
        check(st, "R9 bit stable while clock high", st, 1);
    endtask

    task automatic check_bus(input string req);
        for (int i = 0; i < NRW; i++)
            check(ctl_bus[8*i +: 8] == model[i], req, ctl_bus[8*i +: 8], model[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit a0, a1;
        for (int i = 0; i < NRW; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1: reset state
        check(ctl_bus == '0, "R1 bus after reset", 0, 0);
        check(sda_pull == 1'b0, "R1 line released", sda_pull, 0);

        // R2 / R4: pin low, basic writes
        addr_sel = 1'b0;
        reg_write(8'h94, 8'h00, 8'hA5, "R2 R4 write idx0", 1'b1);
        reg_write(8'h94, 8'h0D, 8'h3C, "R4 write idx13", 1'b1);
        reg_write(8'h94, 8'h06, 8'h81, "R4 write idx6", 1'b1);
        check_bus("R4 bus contents");

        // R5: read back through repeated start
        reg_read(8'h94, 8'h00, 8'hA5, "R5 read idx0");
        reg_read(8'h94, 8'h0D, 8'h3C, "R5 read idx13");
        reg_read(8'h94, 8'h06, 8'h81, "R5 read idx6");

        // R6: status byte
        status_in = 8'h5A;
        reg_read(8'h94, 8'h0E, 8'h5A, "R6 status read");
        status_in = 8'hC3;
        reg_read(8'h94, 8'h0E, 8'hC3, "R6 status follows input");

        // R7: writes to status and beyond ignored but acknowledged
        reg_write(8'h94, 8'h0E, 8'hFF, "R7 write status", 1'b1);
        reg_write(8'h94, 8'h20, 8'h77, "R7 write out of range", 1'b1);
        check_bus("R7 bus unchanged");

        // R8: read beyond status
        reg_read(8'h94, 8'h20, 8'h00, "R8 read idx20h");
        reg_read(8'h94, 8'hFF, 8'h00, "R8 read idxFFh");

        // R3: other pair rejected with pin low, line stays released on later bytes
        reg_write(8'h96, 8'h02, 8'h11, "R3 foreign addr", 1'b0);
        reg_write(8'h30, 8'h02, 8'h11, "R3 random addr", 1'b0);
        check_bus("R3 bus unchanged after NACK");

        // R3: pin high
        addr_sel = 1'b1;
        reg_write(8'h96, 8'h05, 8'h77, "R3 pin high write", 1'b1);
        reg_write(8'h94, 8'h05, 8'h99, "R3 old pair rejected", 1'b0);
        check_bus("R3 bus after pin high");
        reg_read(8'h96, 8'h05, 8'h77, "R3 pin high read");

        // R3: wrong read address after repeated start
        bus_start();
        send_byte(8'h96, a0);
        send_byte(8'h05, a1);
        bus_rstart();
        send_byte(8'h95, a1);
        bus_stop();
        check(a1 == 1'b0, "R3 wrong read addr NACK", a1, 0);

        repeat (20) @(negedge clk);
        check(exp_val.size() == 0, "R5 scoreboard drained", exp_val.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule